// File: doc/BRIEF.md
# Fractional Audio DSP Arithmetic Unit

This block is the execution unit of a small audio effects processor. Each instruction presents a 4-bit opcode and three signed 32-bit operands, named A, X and Y. The unit computes a 32-bit result. The operations are:

- multiply-accumulate in Q31 fractional form and in integer form;
- a three-way add;
- a mask-and-toggle logic step;
- signed compare-and-select limits;
- linear interpolation.

Each arithmetic opcode either clamps or wraps, as its requirement below states. A side accumulator and a condition-code word are updated on every executed instruction. One opcode returns A unchanged while it adds a fractional product into the accumulator.

The unit has no sequencing of its own. A surrounding core fetches the operands and raises `exec_en` for one cycle per instruction. The result, the accumulator, the condition code and the unsupported flag are registered on that edge and held until the next strobe. The core can read them one clock after the strobe. The logarithm, exponent and skip opcodes are not implemented here. For those opcodes the unit returns A and raises the unsupported flag, so the core can handle them elsewhere. The design has no enumerated state machine: its only state is the set of output registers and the accumulator.

Top module: `fx_alu`

## Requirements
- R1: Opcodes 0x0 and 0x2 give A + (X*Y >>> 31), and opcodes 0x1 and 0x3 give A − (X*Y >>> 31). X*Y is the exact 64-bit signed product, and the shift is arithmetic.
- R2: Opcodes 0x0, 0x1, 0x4, 0x6 and 0xE clamp an exact sum above 0x7FFFFFFF to 0x7FFFFFFF, and one below −2^31 to 0x80000000. Condition bit 4 (the saturate flag) is 1 exactly when clamping took place.
- R3: Opcodes 0x2 and 0x3 return the low 32 bits of the exact sum, and the saturate flag is 0.
- R4: Opcode 0x4 gives A + X*Y with the clamping of R2. Opcode 0x5 gives the same sum wrapped to 31 bits: result bits 30..0 are sum bits 30..0, and bit 31 copies sum bit 30.
- R5: Opcode 0x6 gives A + X + Y with the clamping of R2.
- R6: Opcode 0x7 returns A and, in the same cycle, adds the low 32 bits of (X*Y >>> 31) into the accumulator, wrapping. Every other executed opcode loads its result into the accumulator.
- R7: Opcode 0x8 gives (A AND X) XOR Y.
- R8: All comparisons are signed, and the compare opcodes behave as follows:
  - 0x9 gives X when A >= Y, and otherwise gives NOT X.
  - 0xA gives X when A >= Y, and otherwise gives Y.
  - 0xB gives X when A < Y, and otherwise gives Y.
  - For these three opcodes, condition bit 1 (the borrow flag) is 1 when A < Y. For every other opcode it is 0.
- R9: Opcode 0xE gives A + (X*(Y−A) >>> 31), where Y−A is exact at 33 bits, with the clamping of R2.
- R10: Opcodes 0xC, 0xD and 0xF return A with the unsupported flag set to 1. Every other opcode clears that flag.
- R11: The flags below are taken from the final result. They occupy bits 0, 2, 3 and 8 of the 9-bit condition word; bits 5 to 7 are always 0.
  - Bit 2 (minus) is result bit 31.
  - Bit 3 (zero) is 1 when the result is 0.
  - Bit 8 (nonzero) is 1 when the result is not 0.
  - Bit 0 (normalized) is result bit 31 XOR result bit 30.
- R12: The result, accumulator, condition word and unsupported flag change only on a clock edge where `exec_en` is 1. Reset, which is active low, clears all of them to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| exec_en | input | 1 | Executes the presented instruction on this edge |
| opcode | input | 4 | Operation select |
| op_a | input | 32 | Operand A, signed |
| op_x | input | 32 | Operand X, signed |
| op_y | input | 32 | Operand Y, signed |
| res | output | 32 | Registered result |
| acc | output | 32 | Side accumulator |
| ccr | output | 9 | Condition word (bit map in R2, R8, R11) |
| unsup | output | 1 | Last executed opcode was not implemented |

## Verification
Opcode 0x7 performs two functions in one cycle: it passes A to the result while it adds the fractional product into the accumulator. The bench provokes this with operand sets in which A differs from the product. It then judges the result and the accumulator separately against a reference model, and issues consecutive 0x7 instructions to show that the sum carries forward. Saturation and the flag update also share a cycle. The −1 × −1 fractional product is applied to both the clamping opcode and the wrapping opcode, and each case is judged on its result, its saturate flag and its sign-derived flags.

// File: rtl/fx_alu_pkg.sv
package fx_alu_pkg;

    typedef enum logic [3:0] {
        OP_FMAC_SAT   = 4'h0,
        OP_FMSC_SAT   = 4'h1,
        OP_FMAC_WRAP  = 4'h2,
        OP_FMSC_WRAP  = 4'h3,
        OP_IMAC_SAT   = 4'h4,
        OP_IMAC_W31   = 4'h5,
        OP_ADD3_SAT   = 4'h6,
        OP_PASS_ACC   = 4'h7,
        OP_MASKXOR    = 4'h8,
        OP_SIGNSEL    = 4'h9,
        OP_SEL_GE     = 4'hA,
        OP_SEL_LT     = 4'hB,
        OP_RSV_C      = 4'hC,
        OP_RSV_D      = 4'hD,
        OP_LERP       = 4'hE,
        OP_RSV_F      = 4'hF
    } alu_op_e;

    localparam int CC_W       = 9;
    localparam int CC_NORM    = 0;
    localparam int CC_BORROW  = 1;
    localparam int CC_MINUS   = 2;
    localparam int CC_ZERO    = 3;
    localparam int CC_SAT     = 4;
    localparam int CC_NONZERO = 8;

endpackage

// File: rtl/fx_alu_mul.sv
module fx_alu_mul #(
    parameter int W = 32
) (
    input  logic signed [W-1:0] mul_a,
    input  logic signed [W:0]   mul_b,
    output logic signed [2*W:0] prod
);
    // Product of a W-bit and a (W+1)-bit signed value; magnitude stays below 2^(2W).
    assign prod = mul_a * mul_b;
endmodule

// File: rtl/fx_alu_clamp.sv
module fx_alu_clamp #(
    parameter int W  = 32,
    parameter int WW = 67
) (
    input  logic signed [WW-1:0] sum,
    input  logic                 sat_mode,
    input  logic                 w31_mode,
    output logic [W-1:0]         val,
    output logic                 clamped
);
    localparam logic signed [WW-1:0] MAX_POS = WW'({1'b0, {(W-1){1'b1}}});
    localparam logic signed [WW-1:0] MIN_NEG = -MAX_POS - WW'(1);

    logic hi, lo;
    assign hi = sum > MAX_POS;
    assign lo = sum < MIN_NEG;

    always_comb begin
        clamped = 1'b0;
        if (w31_mode) begin
            val = {sum[W-2], sum[W-2:0]};
        end else if (sat_mode && hi) begin
            val     = {1'b0, {(W-1){1'b1}}};
            clamped = 1'b1;
        end else if (sat_mode && lo) begin
            val     = {1'b1, {(W-1){1'b0}}};
            clamped = 1'b1;
        end else begin
            val = sum[W-1:0];
        end
    end
endmodule

// File: rtl/fx_alu_logic.sv
module fx_alu_logic
    import fx_alu_pkg::*;
#(
    parameter int W = 32
) (
    input  alu_op_e              op,
    input  logic signed [W-1:0]  a,
    input  logic signed [W-1:0]  x,
    input  logic signed [W-1:0]  y,
    output logic [W-1:0]         val,
    output logic                 is_cmp,
    output logic                 a_lt_y
);
    assign a_lt_y = a < y;

    always_comb begin
        is_cmp = 1'b0;
        unique case (op)
            OP_MASKXOR: val = (a & x) ^ y;
            OP_SIGNSEL: begin val = a_lt_y ? ~x : x; is_cmp = 1'b1; end
            OP_SEL_GE:  begin val = a_lt_y ? y : x;  is_cmp = 1'b1; end
            OP_SEL_LT:  begin val = a_lt_y ? x : y;  is_cmp = 1'b1; end
            default:    val = a;
        endcase
    end
endmodule

// File: rtl/fx_alu.sv
module fx_alu
    import fx_alu_pkg::*;
#(
    parameter int W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              exec_en,
    input  logic [3:0]        opcode,
    input  logic [W-1:0]      op_a,
    input  logic [W-1:0]      op_x,
    input  logic [W-1:0]      op_y,
    output logic [W-1:0]      res,
    output logic [W-1:0]      acc,
    output logic [CC_W-1:0]   ccr,
    output logic              unsup
);
    localparam int PW = 2*W + 1;   // product width
    localparam int WW = 2*W + 3;   // adder width, holds A + X*Y exactly

    alu_op_e op;
    assign op = alu_op_e'(opcode);

    logic signed [W-1:0]  sa, sx, sy;
    assign sa = op_a;
    assign sx = op_x;
    assign sy = op_y;

    // Second multiplier operand: Y, or Y - A for interpolation
    logic signed [W:0]  y_ext, a_ext, y_m_a, mul_b;
    assign y_ext = {sy[W-1], sy};
    assign a_ext = {sa[W-1], sa};
    assign y_m_a = y_ext - a_ext;
    assign mul_b = (op == OP_LERP) ? y_m_a : y_ext;

    logic signed [PW-1:0] prod, prod_q31;
    fx_alu_mul #(.W(W)) u_mul (.mul_a(sx), .mul_b(mul_b), .prod(prod));
    assign prod_q31 = prod >>> (W-1);

    logic signed [WW-1:0] wa, wx, wy, wprod, wfrac, sum;
    assign wa    = {{(WW-W){sa[W-1]}}, sa};
    assign wx    = {{(WW-W){sx[W-1]}}, sx};
    assign wy    = {{(WW-W){sy[W-1]}}, sy};
    assign wprod = {{(WW-PW){prod[PW-1]}}, prod};
    assign wfrac = {{(WW-PW){prod_q31[PW-1]}}, prod_q31};

    always_comb begin
        unique case (op)
            OP_FMAC_SAT, OP_FMAC_WRAP, OP_LERP: sum = wa + wfrac;
            OP_FMSC_SAT, OP_FMSC_WRAP:          sum = wa - wfrac;
            OP_IMAC_SAT, OP_IMAC_W31:           sum = wa + wprod;
            OP_ADD3_SAT:                        sum = wa + wx + wy;
            default:                            sum = wa;
        endcase
    end

    logic sat_mode, w31_mode, arith_op, unsup_d;
    always_comb begin
        sat_mode = 1'b0;
        w31_mode = 1'b0;
        arith_op = 1'b0;
        unsup_d  = 1'b0;
        unique case (op)
            OP_FMAC_SAT, OP_FMSC_SAT, OP_IMAC_SAT, OP_ADD3_SAT, OP_LERP: begin
                sat_mode = 1'b1; arith_op = 1'b1;
            end
            OP_FMAC_WRAP, OP_FMSC_WRAP: arith_op = 1'b1;
            OP_IMAC_W31: begin w31_mode = 1'b1; arith_op = 1'b1; end
            OP_RSV_C, OP_RSV_D, OP_RSV_F: unsup_d = 1'b1;
            default: ;
        endcase
    end

    logic [W-1:0] arith_val, logic_val, r_d;
    logic         clamped, is_cmp, a_lt_y;

    fx_alu_clamp #(.W(W), .WW(WW)) u_clamp (
        .sum(sum), .sat_mode(sat_mode), .w31_mode(w31_mode),
        .val(arith_val), .clamped(clamped)
    );

    fx_alu_logic #(.W(W)) u_logic (
        .op(op), .a(sa), .x(sx), .y(sy),
        .val(logic_val), .is_cmp(is_cmp), .a_lt_y(a_lt_y)
    );

    assign r_d = arith_op ? arith_val : logic_val;

    logic [CC_W-1:0] cc_d;
    always_comb begin
        cc_d              = '0;
        cc_d[CC_NORM]     = r_d[W-1] ^ r_d[W-2];
        cc_d[CC_BORROW]   = is_cmp & a_lt_y;
        cc_d[CC_MINUS]    = r_d[W-1];
        cc_d[CC_ZERO]     = (r_d == '0);
        cc_d[CC_SAT]      = clamped;
        cc_d[CC_NONZERO]  = (r_d != '0);
    end

    logic [W-1:0] acc_d;
    assign acc_d = (op == OP_PASS_ACC) ? (acc + prod_q31[W-1:0]) : r_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            res   <= '0;
            acc   <= '0;
            ccr   <= '0;
            unsup <= 1'b0;
        end else if (exec_en) begin
            res   <= r_d;
            acc   <= acc_d;
            ccr   <= cc_d;
            unsup <= unsup_d;
        end
    end

    // R12: registered state holds while no instruction executes
    a_r12_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !exec_en |=> ($stable(res) && $stable(acc) && $stable(ccr) && $stable(unsup)));

    // R2: a set saturate flag implies the result sits on a rail
    a_r2_rail: assert property (@(posedge clk) disable iff (!rst_n)
        ccr[CC_SAT] |-> (res == {1'b0, {(W-1){1'b1}}} || res == {1'b1, {(W-1){1'b0}}}));

    // R6: the pass-through opcode returns A
    a_r6_pass: assert property (@(posedge clk) disable iff (!rst_n)
        (exec_en && opcode == 4'h7) |=> (res == $past(op_a)));

    // R10: unimplemented opcodes flag and return A
    a_r10_unsup: assert property (@(posedge clk) disable iff (!rst_n)
        (exec_en && (opcode == 4'hC || opcode == 4'hD || opcode == 4'hF))
        |=> (unsup && res == $past(op_a)));

    // R8: limit select returns one of its two candidates
    a_r8_select: assert property (@(posedge clk) disable iff (!rst_n)
        (exec_en && (opcode == 4'hA || opcode == 4'hB))
        |=> (res == $past(op_x) || res == $past(op_y)));

    // R11: zero and nonzero flags never both set
    a_r11_zflags: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({ccr[CC_ZERO], ccr[CC_NONZERO]}));
endmodule

// File: tb/tb_fx_alu.sv
`timescale 1ns/1ps
module tb_fx_alu;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        exec_en = 1'b0;
    logic [3:0]  opcode = '0;
    logic [31:0] op_a = '0, op_x = '0, op_y = '0;
    logic [31:0] res, acc;
    logic [8:0]  ccr;
    logic        unsup;

    int checks = 0;
    int fails  = 0;
    logic [31:0] exp_acc = '0;

    always #2.5 clk = ~clk;

    fx_alu dut (.clk(clk), .rst_n(rst_n), .exec_en(exec_en), .opcode(opcode),
                .op_a(op_a), .op_x(op_x), .op_y(op_y),
                .res(res), .acc(acc), .ccr(ccr), .unsup(unsup));

    task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] expv);
        checks++;
        if (act !== expv) begin
            fails++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, expv);
        end
    endtask

    // Reference computation built from the requirements
    task automatic model(input logic [3:0] op, input logic signed [31:0] a, x, y,
                         output logic [31:0] r, output logic [8:0] cc, output logic un,
                         output logic [31:0] frac_lo);
        logic signed [127:0] A, X, Y, s, f;
        logic sat, brw, clampable;
        A = a; X = x; Y = y;
        f = (X * Y) >>> 31;
        frac_lo = f[31:0];
        sat = 0; brw = 0; un = 0; clampable = 0; s = A;
        case (op)
            4'h0: begin s = A + f; clampable = 1; end
            4'h1: begin s = A - f; clampable = 1; end
            4'h2: s = A + f;
            4'h3: s = A - f;
            4'h4: begin s = A + X * Y; clampable = 1; end
            4'h5: s = A + X * Y;
            4'h6: begin s = A + X + Y; clampable = 1; end
            4'h7: s = A;
            4'h8: s = {96'd0, (a & x) ^ y};
            4'h9: begin brw = (A < Y); s = {96'd0, brw ? ~x : x}; end
            4'hA: begin brw = (A < Y); s = {96'd0, brw ? y : x}; end
            4'hB: begin brw = (A < Y); s = {96'd0, brw ? x : y}; end
            4'hE: begin s = A + ((X * (Y - A)) >>> 31); clampable = 1; end
            default: begin s = A; un = 1; end
        endcase
        if (clampable && s > 128'sh7FFFFFFF) begin r = 32'h7FFFFFFF; sat = 1; end
        else if (clampable && s < -128'sh80000000) begin r = 32'h80000000; sat = 1; end
        else if (op == 4'h5) r = {s[30], s[30:0]};
        else r = s[31:0];
        cc = '0;
        cc[0] = r[31] ^ r[30];
        cc[1] = brw;
        cc[2] = r[31];
        cc[3] = (r == 0);
        cc[4] = sat;
        cc[8] = (r != 0);
    endtask

    task automatic run(input string req, input logic [3:0] op, input logic [31:0] a, x, y);
        logic [31:0] r, fl; logic [8:0] cc; logic un;
        model(op, a, x, y, r, cc, un, fl);
        if (op == 4'h7) exp_acc = exp_acc + fl; else exp_acc = r;
        @(negedge clk);
        opcode = op; op_a = a; op_x = x; op_y = y; exec_en = 1'b1;
        @(negedge clk);
        exec_en = 1'b0;
        chk(req, "res", res, r);
        chk(req, "ccr", {23'd0, ccr}, {23'd0, cc});
        chk(req, "unsup", {31'd0, unsup}, {31'd0, un});
        chk("R6", "acc", acc, exp_acc);
    endtask

    task automatic t_reset;
        chk("R12", "reset res", res, 0);
        chk("R12", "reset acc", acc, 0);
        chk("R12", "reset ccr", {23'd0, ccr}, 0);
        chk("R12", "reset unsup", {31'd0, unsup}, 0);
    endtask

    task automatic t_frac_mac;
        run("R1", 4'h0, 32'h10000000, 32'h40000000, 32'h40000000);
        run("R1", 4'h1, 32'h10000000, 32'h40000000, 32'h40000000);
        run("R1", 4'h2, 32'hF0000000, 32'hC0000000, 32'h20000000);
        run("R1", 4'h3, 32'h00000005, 32'h12345678, 32'h9ABCDEF0);
        // -1 * -1 fractional: clamps at 0x0, wraps at 0x2
        run("R2", 4'h0, 32'h0, 32'h80000000, 32'h80000000);
        chk("R2", "hard clamp", res, 32'h7FFFFFFF);
        chk("R2", "sat flag", {31'd0, ccr[4]}, 1);
        run("R3", 4'h2, 32'h0, 32'h80000000, 32'h80000000);
        chk("R3", "hard wrap", res, 32'h80000000);
        chk("R3", "no sat flag", {31'd0, ccr[4]}, 0);
        run("R2", 4'h1, 32'h80000000, 32'h7FFFFFFF, 32'h7FFFFFFF);
        chk("R2", "neg clamp", res, 32'h80000000);
    endtask

    task automatic t_int;
        run("R4", 4'h4, 32'd100, 32'd7, 32'hFFFFFFFD);
        run("R4", 4'h4, 32'h7FFFFF00, 32'h00010000, 32'h00010000);
        run("R4", 4'h5, 32'h3FFFFFFF, 32'd1, 32'd1);
        chk("R4", "31-bit wrap", res, 32'hC0000000);
        run("R4", 4'h5, 32'd10, 32'd3, 32'd4);
    endtask

    task automatic t_add3;
        run("R5", 4'h6, 32'd1, 32'd2, 32'hFFFFFFFC);
        run("R5", 4'h6, 32'h7FFFFFFF, 32'h7FFFFFFF, 32'h7FFFFFFF);
        run("R5", 4'h6, 32'h80000000, 32'h80000000, 32'h80000000);
    endtask

    task automatic t_pass_acc;
        run("R6", 4'h8, 32'h0, 32'h0, 32'h00001000);
        run("R6", 4'h7, 32'hDEADBEEF, 32'h40000000, 32'h40000000);
        chk("R6", "pass A", res, 32'hDEADBEEF);
        chk("R6", "acc sum", acc, 32'h20001000);
        run("R6", 4'h7, 32'h00000001, 32'h80000000, 32'h80000000);
        run("R6", 4'h7, 32'h0, 32'hC0000000, 32'h40000000);
    endtask

    task automatic t_logic;
        run("R7", 4'h8, 32'hFF00FF00, 32'h0F0F0F0F, 32'h12345678);
        run("R7", 4'h8, 32'hAAAAAAAA, 32'hFFFFFFFF, 32'hAAAAAAAA);
    endtask

    task automatic t_compare;
        run("R8", 4'h9, 32'd5, 32'h00FF00FF, 32'd5);
        run("R8", 4'h9, 32'hFFFFFFFF, 32'h00FF00FF, 32'd1);
        run("R8", 4'hA, 32'h80000000, 32'd11, 32'h7FFFFFFF);
        chk("R8", "signed ge", res, 32'h7FFFFFFF);
        chk("R8", "borrow", {31'd0, ccr[1]}, 1);
        run("R8", 4'hA, 32'd9, 32'd11, 32'hFFFFFFF0);
        run("R8", 4'hB, 32'hFFFFFFFE, 32'd3, 32'd4);
        run("R8", 4'hB, 32'd4, 32'd3, 32'd4);
    endtask

    task automatic t_interp;
        run("R9", 4'hE, 32'h0, 32'h40000000, 32'h40000000);
        chk("R9", "half way", res, 32'h20000000);
        run("R9", 4'hE, 32'h10000000, 32'h20000000, 32'h70000000);
        run("R9", 4'hE, 32'h80000000, 32'h80000000, 32'h7FFFFFFF);
        run("R9", 4'hE, 32'h7FFFFFFF, 32'h80000000, 32'h80000000);
    endtask

    task automatic t_unsup;
        run("R10", 4'hC, 32'h0000ABCD, 32'h1, 32'h2);
        run("R10", 4'hD, 32'h0, 32'h1, 32'h2);
        run("R10", 4'hF, 32'h80000000, 32'h1, 32'h2);
        run("R10", 4'h6, 32'h1, 32'h1, 32'h1);
    endtask

    task automatic t_flags;
        run("R11", 4'h8, 32'h0, 32'h0, 32'h40000000);
        run("R11", 4'h8, 32'h0, 32'h0, 32'hC0000000);
        run("R11", 4'h8, 32'h0, 32'h0, 32'h0);
        chk("R11", "zero flag", {31'd0, ccr[3]}, 1);
    endtask

    task automatic t_hold;
        logic [31:0] r0, a0; logic [8:0] c0;
        r0 = res; a0 = acc; c0 = ccr;
        @(negedge clk);
        opcode = 4'h6; op_a = 32'h123; op_x = 32'h456; op_y = 32'h789; exec_en = 1'b0;
        repeat (3) @(negedge clk);
        chk("R12", "hold res", res, r0);
        chk("R12", "hold acc", acc, a0);
        chk("R12", "hold ccr", {23'd0, ccr}, {23'd0, c0});
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_frac_mac();
        t_int();
        t_add3();
        t_pass_acc();
        t_logic();
        t_compare();
        t_interp();
        t_unsup();
        t_flags();
        t_hold();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule